// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver

This block is a serial line transceiver with a separate transmit path and receive path that work at the same time on their own wires. Both paths share one programmable bit period, counted in base clocks, and one selectable word length of 7, 8 or 9 data bits. Frames carry no parity. Data bits travel least significant bit first between a low start bit and a high stop bit.

Words to send enter through a valid/ready handshake. A word moves when `tx_valid` and `tx_ready` are both high at a rising clock edge. Once `tx_valid` is raised, the producer holds it and `tx_word` steady until that edge. `tx_ready` stays low while a frame is on the line, and that is the only back-pressure. If the producer already has the next word waiting when the first stop bit ends, the transmitter adds a second stop bit. It then takes the next word at the last cycle of that second stop bit, with no idle gap. A frame with nothing queued behind it ends after one stop bit.

The receiver looks for a falling edge on a synchronised copy of the line. It confirms the start bit half a period later and samples every later bit at its centre. For each frame it gives out the right-aligned word with a one-cycle `rx_valid` strobe and a framing-error flag. The receive side has no back-pressure, so the consumer must take the word in the strobe cycle. `bit_period` and `word_len` may change only while both paths are idle.

Top module: `uart_dx`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high and `rx_valid` is low, and `txd` stays high whenever no frame is being sent.
- R2: A word is taken in the cycle where `tx_valid` and `tx_ready` are both high. The start bit (low) begins on `txd` in the next cycle, and `tx_ready` stays low until the frame has finished.
- R3: `word_len` selects the number of data bits: 2'b00 gives 7, 2'b01 gives 8, and 2'b10 or 2'b11 gives 9. Bits are sent and received least significant bit first with no parity bit. On transmit, bits of `tx_word` above the selected length are ignored. On receive, the word is right-aligned in `rx_word` and the bits above the length are zero.
- R4: A frame with `tx_valid` low at the end of its stop bit has one stop bit. `tx_ready` is low for exactly (length+2)×`bit_period` falling clock edges after acceptance.
- R5: If `tx_valid` is high when the first stop bit ends, a second high stop bit follows. The next word is taken on the last cycle of that second stop bit, so successive acceptances are exactly (length+3)×`bit_period` cycles apart.
- R6: A low pulse on `rxd` that has ended by half a bit period after the falling edge is rejected. It produces no `rx_valid`, and the receiver then takes the next proper frame correctly.
- R7: The receiver samples each data bit at its centre and raises `rx_valid` for exactly one cycle per frame, presenting the received word on `rx_word`.
- R8: `rx_frame_err` is 1 together with `rx_valid` when the stop bit is sampled low, and 0 when it is sampled high.
- R9: Transmit and receive run at the same time without disturbing each other.
- R10: Each bit on `txd` lasts exactly `bit_period` base clocks for any period from 16 to 8192, odd values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_period | input | 14 | Bit time in base clocks (16 to 8192) |
| word_len | input | 2 | Data length select: 00=7, 01=8, 1x=9 |
| tx_word | input | 9 | Word to transmit, right-aligned |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmitter can take a word this cycle |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rx_word | output | 9 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_frame_err | output | 1 | Stop bit of the presented word was low |

## Verification
Some properties are checked on every cycle. The line is high whenever the transmitter is idle or in its extra stop bit, and a start bit always follows an acceptance. The line holds steady through the centre of each bit, and the bit counter never reaches the programmed period. The receive strobe never lasts two cycles, and a 7-bit word never carries stray upper bits. Other behaviours depend on exact counts over a whole frame, so only the bench's directed scenarios can show them. These are the one-stop versus two-stop spacing, the bit order and masking for each length, glitch rejection followed by recovery, framing-error reporting and simultaneous traffic in both directions.

// File: rtl/uart_dx_pkg.sv
package uart_dx_pkg;
  localparam int WORD_W = 9;
  localparam int IDX_W  = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_STOP2} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // number of data bits for a length select code
  function automatic idx_t frame_bits(input logic [1:0] sel);
    case (sel)
      2'b00:   frame_bits = idx_t'(7);
      2'b01:   frame_bits = idx_t'(8);
      default: frame_bits = idx_t'(9);
    endcase
  endfunction
endpackage

// File: rtl/uart_dx_bitclk.sv
module uart_dx_bitclk #(
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                mid,
  output logic                last
);
  localparam logic [PERIOD_W-1:0] P_ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] half;

  assign half = period >> 1;
  assign last = run && (cnt == period - P_ONE);
  assign mid  = run && (cnt == half - P_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!run || restart || last) cnt <= '0;
    else                             cnt <= cnt + P_ONE;
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));
endmodule

// File: rtl/uart_dx_tx.sv
module uart_dx_tx
  import uart_dx_pkg::*;
#(
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic [1:0]          len_sel,
  input  word_t               in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                txd
);
  localparam idx_t IDX_ONE = idx_t'(1);

  tx_state_e st;
  word_t     shreg;
  idx_t      idx;
  idx_t      nbits;
  logic      txd_q;
  logic      mid, last, load;

  assign nbits    = frame_bits(len_sel);
  assign in_ready = (st == TX_IDLE) || ((st == TX_STOP2) && last);
  assign load     = in_valid && in_ready;
  assign txd      = txd_q;

  uart_dx_bitclk #(.PERIOD_W(PERIOD_W)) i_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st != TX_IDLE),
    .restart (1'b0),
    .period  (period),
    .mid     (mid),
    .last    (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      shreg <= '0;
      idx   <= '0;
      txd_q <= 1'b1;
    end else if (load) begin
      st    <= TX_START;
      shreg <= in_data;
      idx   <= '0;
      txd_q <= 1'b0;
    end else if (last) begin
      unique case (st)
        TX_START: begin
          st    <= TX_DATA;
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
          idx   <= '0;
        end
        TX_DATA: begin
          if (idx == nbits - IDX_ONE) begin
            st    <= TX_STOP;
            txd_q <= 1'b1;
          end else begin
            idx   <= idx + IDX_ONE;
            txd_q <= shreg[0];
            shreg <= shreg >> 1;
          end
        end
        TX_STOP:  st <= in_valid ? TX_STOP2 : TX_IDLE;
        default:  st <= TX_IDLE;
      endcase
    end
  end

  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE) |-> txd);
  // R5
  tx_stop2_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_STOP2) |-> txd);
  // R10
  txd_mid_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid |-> $stable(txd));
endmodule

// File: rtl/uart_dx_rx.sv
module uart_dx_rx
  import uart_dx_pkg::*;
#(
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic [1:0]          len_sel,
  input  logic                rxd,
  output word_t               out_data,
  output logic                out_valid,
  output logic                out_err
);
  localparam idx_t IDX_ONE = idx_t'(1);
  localparam idx_t W_IDX   = idx_t'(WORD_W);

  rx_state_e st;
  logic      s1, s2, prev;
  logic      fall, mid, last;
  word_t     sh;
  idx_t      idx;
  idx_t      nbits;

  assign nbits = frame_bits(len_sel);
  assign fall  = prev && !s2;

  uart_dx_bitclk #(.PERIOD_W(PERIOD_W)) i_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st != RX_IDLE),
    .restart ((st == RX_START) && mid),
    .period  (period),
    .mid     (mid),
    .last    (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      sh        <= '0;
      idx       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        RX_IDLE: if (fall) st <= RX_START;
        RX_START: if (mid) begin
          if (!s2) begin
            st  <= RX_DATA;
            idx <= '0;
          end else begin
            st <= RX_IDLE;
          end
        end
        RX_DATA: if (last) begin
          sh <= {s2, sh[WORD_W-1:1]};
          if (idx == nbits - IDX_ONE) st <= RX_STOP;
          else                        idx <= idx + IDX_ONE;
        end
        default: if (last) begin
          out_valid <= 1'b1;
          out_err   <= !s2;
          out_data  <= sh >> (W_IDX - nbits);
          st        <= RX_IDLE;
        end
      endcase
    end
  end

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R3
  rx_short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (nbits == idx_t'(7))) |-> ((out_data >> 7) == '0));
endmodule

// File: rtl/uart_dx.sv
module uart_dx
  import uart_dx_pkg::*;
#(
  parameter int PERIOD_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] bit_period,
  input  logic [1:0]          word_len,
  input  logic [WORD_W-1:0]   tx_word,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                txd,
  input  logic                rxd,
  output logic [WORD_W-1:0]   rx_word,
  output logic                rx_valid,
  output logic                rx_frame_err
);
  uart_dx_tx #(.PERIOD_W(PERIOD_W)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .period   (bit_period),
    .len_sel  (word_len),
    .in_data  (tx_word),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .txd      (txd)
  );

  uart_dx_rx #(.PERIOD_W(PERIOD_W)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (bit_period),
    .len_sel   (word_len),
    .rxd       (rxd),
    .out_data  (rx_word),
    .out_valid (rx_valid),
    .out_err   (rx_frame_err)
  );
endmodule

// File: tb/test_uart_dx.sv
module test_uart_dx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bit_period = 14'd16;
  logic [1:0]  word_len = 2'b01;
  logic [8:0]  tx_word = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic [8:0]  rx_word;
  logic        rx_valid, rx_frame_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_dx i_uart_dx (
    .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .word_len(word_len),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_word(rx_word), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  function automatic int len_of(input logic [1:0] sel);
    return (sel == 2'b00) ? 7 : (sel == 2'b01) ? 8 : 9;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input int p, input logic [1:0] sel);
    @(negedge clk);
    bit_period = 14'(p);
    word_len   = sel;
  endtask

  // decodes one frame from txd, sampling at negedges near bit centres
  task automatic tx_monitor(input int p, input int nb, output logic [8:0] w, output bit stop_hi);
    w = '0;
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (p) @(negedge clk);
      w[i] = txd;
    end
    repeat (p) @(negedge clk);
    stop_hi = txd;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(tx_ready == 1'b1, "R1 tx_ready after reset", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);
  endtask

  task automatic t_tx_single(input int p, input logic [1:0] sel, input logic [8:0] w, output bit ok);
    int nb, lowcnt;
    logic [8:0] got, expw;
    bit stop_hi;
    nb = len_of(sel);
    expw = w & 9'((1 << nb) - 1);
    setup(p, sel);
    fork
      begin
        tx_word = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        lowcnt = 0;
        while (!tx_ready) begin
          lowcnt++;
          @(negedge clk);
        end
      end
      tx_monitor(p, nb, got, stop_hi);
    join
    // R2 / R4: ready low for the whole one-stop frame
    chk(lowcnt == (nb + 2) * p, "R4 ready-low cycles single frame", lowcnt, (nb + 2) * p);
    // R3 / R10: LSB-first bits, upper bits ignored
    chk(got == expw, "R3 transmitted word", int'(got), int'(expw));
    chk(stop_hi == 1'b1, "R4 stop bit high", int'(stop_hi), 1);
    ok = (got == expw) && stop_hi && (lowcnt == (nb + 2) * p);
  endtask

  task automatic t_tx_pair(input int p, input logic [1:0] sel, input logic [8:0] w0, input logic [8:0] w1);
    int nb, lowcnt;
    logic [8:0] g0, g1;
    bit s0, s1;
    nb = len_of(sel);
    setup(p, sel);
    fork
      begin
        tx_word = w0;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_word = w1;
        lowcnt = 0;
        while (!tx_ready) begin
          lowcnt++;
          @(negedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready) @(negedge clk);
      end
      begin
        tx_monitor(p, nb, g0, s0);
        tx_monitor(p, nb, g1, s1);
      end
    join
    // R5: second stop bit inserted, next word taken with no idle gap
    chk(lowcnt == (nb + 3) * p - 1, "R5 back-to-back acceptance spacing", lowcnt, (nb + 3) * p - 1);
    chk(g0 == w0, "R5 first word of pair", int'(g0), int'(w0));
    chk(g1 == w1, "R5 second word of pair", int'(g1), int'(w1));
    chk(s0 && s1, "R5 stop bits high", int'(s0 && s1), 1);
  endtask

  task automatic rx_drive(input int p, input int nb, input logic [8:0] w, input logic stop_v);
    rxd = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = w[i];
      repeat (p) @(negedge clk);
    end
    rxd = stop_v;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic t_rx(input int p, input logic [1:0] sel, input logic [8:0] w,
                      input logic stop_v, output bit ok);
    int nb, pulses;
    logic [8:0] got, expw;
    logic err;
    nb = len_of(sel);
    expw = w & 9'((1 << nb) - 1);
    setup(p, sel);
    pulses = 0;
    got = '0;
    err = 1'b0;
    fork
      rx_drive(p, nb, w, stop_v);
      for (int i = 0; i < (nb + 3) * p; i++) begin
        @(negedge clk);
        if (rx_valid) begin
          pulses++;
          got = rx_word;
          err = rx_frame_err;
        end
      end
    join
    // R7: exactly one strobe, centre-sampled word, right-aligned (R3)
    chk(pulses == 1, "R7 rx_valid strobe count", pulses, 1);
    chk(got == expw, "R7 received word", int'(got), int'(expw));
    // R8
    chk(err == !stop_v, "R8 framing error flag", int'(err), int'(!stop_v));
    ok = (pulses == 1) && (got == expw) && (err == !stop_v);
  endtask

  task automatic t_glitch(input int p);
    int pulses;
    bit ok;
    setup(p, 2'b01);
    rxd = 1'b0;
    repeat (p / 4) @(negedge clk);
    rxd = 1'b1;
    pulses = 0;
    for (int i = 0; i < 3 * p; i++) begin
      @(negedge clk);
      if (rx_valid) pulses++;
    end
    // R6
    chk(pulses == 0, "R6 glitch rejected", pulses, 0);
    t_rx(p, 2'b01, 9'h0C9, 1'b1, ok);
    chk(ok, "R6 recovery after glitch", int'(ok), 1);
  endtask

  task automatic t_duplex(input int p);
    bit ok_t, ok_r;
    fork
      t_tx_single(p, 2'b01, 9'h03C, ok_t);
      t_rx(p, 2'b01, 9'h0E1, 1'b1, ok_r);
    join
    // R9
    chk(ok_t && ok_r, "R9 simultaneous transmit and receive", int'(ok_t && ok_r), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_tx_single(16, 2'b01, 9'h0A5, ok);
    t_tx_single(23, 2'b00, 9'h1FF, ok);   // R10 odd period, R3 masking
    t_tx_single(16, 2'b10, 9'h13C, ok);
    t_tx_single(17, 2'b11, 9'h155, ok);
    t_tx_single(200, 2'b00, 9'h05A, ok);  // R10 long period
    t_tx_pair(16, 2'b01, 9'h0C3, 9'h01E);
    t_rx(16, 2'b01, 9'h05A, 1'b1, ok);
    t_rx(20, 2'b00, 9'h1B3, 1'b1, ok);
    t_rx(16, 2'b10, 9'h1C3, 1'b1, ok);
    t_rx(16, 2'b01, 9'h077, 1'b0, ok);
    t_glitch(16);
    t_duplex(16);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule